// File: doc/BRIEF.md
# Strobed Output Port Handshake

This block drives one byte-wide output port toward a peripheral using a two-wire handshake. A CPU write strobe loads a byte into the port latch, and the latch drives the port pins continuously from then on. When the strobe is released, an active-low buffer-full line tells the peripheral that a byte is waiting. The peripheral takes the byte and pulls its active-low acknowledge line low, which releases buffer-full. Once acknowledge returns high, and if interrupts are enabled, the block raises an interrupt request so the CPU can send the next byte. The enable flip-flop is written through a single-bit set/reset hook addressed by a port C bit index.

The CPU strobe and the acknowledge line are asynchronous, so both pass through a synchronizer of `SYNC_STAGES` flops. The data bus goes through a delay line of the same depth, so each byte stays aligned with its strobe. Flow control is carried by levels, not by a valid/ready pair. Buffer-full low means the consumer has not yet taken the byte. The producer (the CPU) is expected to wait for the interrupt, or for buffer-full high, before its next write. A write made while buffer-full is low replaces the byte and is not refused. The peripheral consumes a byte only by pulsing acknowledge.

Top module: `strobed_out_port`

## Requirements
- R1: Reset drives `obf_n` high, `intr` low and `port_dout` to zero, and clears the interrupt enable. With the enable cleared, no request rises afterwards until the enable is set again.
- R2: `port_dout` takes the byte presented on `cpu_wdata` while `cpu_wr_n` is low. `obf_n` falls only after `cpu_wr_n` rises, and on the cycle `obf_n` falls `port_dout` already shows the new byte.
- R3: While `cpu_wr_n` is high, `port_dout` holds its value whatever `cpu_wdata` does.
- R4: `obf_n` stays low until `per_ack_n` is seen low. A low `per_ack_n` returns `obf_n` high.
- R5: `intr` rises only when all of the following hold: acknowledge is high, `obf_n` is high, the enable is set and no write strobe is active. Enabling with an empty buffer therefore raises `intr`.
- R6: The falling edge of `cpu_wr_n` clears `intr`, and `intr` stays low while the strobe remains low.
- R7: A one-cycle `bsr_stb` pulse whose `bsr_sel` equals the enable index sets the enable to `bsr_val`. The index is 6 for the A-side port variant and 2 for the B-side variant. A pulse with any other index leaves the enable unchanged.
- R8: Clearing the enable drops `intr` on the next clock and blocks new requests.
- R9: A level change on `cpu_wr_n` or `per_ack_n` first appears on `port_dout`, `obf_n` or `intr` at the rising clock edge numbered `SYNC_STAGES+1` after the change. With the default of 2, that is the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_n | input | 1 | CPU write strobe to this port, active low, asynchronous |
| cpu_wdata | input | DATA_W | CPU data bus, stable while the strobe is low |
| per_ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| bsr_stb | input | 1 | One-cycle pulse of a port C single-bit set/reset write |
| bsr_sel | input | 3 | Port C bit index of that write |
| bsr_val | input | 1 | Value written to the selected bit |
| port_dout | output | DATA_W | Output latch driving the port pins |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request to the CPU |

## Verification
A buffer-full flag stuck in the wrong state shows on `obf_n` within `SYNC_STAGES+1` clocks of the next strobe edge or acknowledge. The peripheral would then either wait forever or take a byte twice. An enable flip-flop holding the wrong value shows on `intr` one clock after it is written or after an acknowledge completes. A latch that updates at the wrong moment shows on `port_dout` when `obf_n` falls, or when the bus changes after the strobe has risen. The bench samples every one of these points at the exact clock edge where the outputs must change.

// File: rtl/ppo_pkg.sv
package ppo_pkg;
  localparam int PC_IDX_W = 3;

  typedef enum logic [0:0] {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_sel_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  // Port C bit index that holds the interrupt enable of each port variant
  function automatic logic [PC_IDX_W-1:0] inte_index(port_sel_e p);
    return (p == PORT_B) ? 3'd2 : 3'd6;
  endfunction
endpackage

// File: rtl/ppo_sync.sv
module ppo_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] r;
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= RST_VAL;
          else        r <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= RST_VAL;
          else        r <= g_stage[s-1].r;
        end
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/ppo_edge.sv
module ppo_edge
  import ppo_pkg::*;
#(
  parameter logic RST_VAL = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lvl,
  output edge_t ev
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign ev.rise = lvl & ~prev_q;
  assign ev.fall = ~lvl & prev_q;
endmodule

// File: rtl/ppo_inte.sv
module ppo_inte
  import ppo_pkg::*;
#(
  parameter port_sel_e PORT = PORT_A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bsr_stb,
  input  logic [PC_IDX_W-1:0] bsr_sel,
  input  logic                bsr_val,
  output logic                inte
);
  localparam logic [PC_IDX_W-1:0] TARGET = inte_index(PORT);

  logic hit;
  assign hit = bsr_stb && (bsr_sel == TARGET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   inte <= 1'b0;
    else if (hit) inte <= bsr_val;
  end

  AST_INTE_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsr_stb && bsr_sel == TARGET) |=> $stable(inte)); // R7
  AST_INTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_stb && bsr_sel == TARGET) |=> (inte == $past(bsr_val))); // R7
endmodule

// File: rtl/strobed_out_port.sv
module strobed_out_port
  import ppo_pkg::*;
#(
  parameter int        DATA_W      = 8,
  parameter int        SYNC_STAGES = 2,
  parameter port_sel_e PORT        = PORT_A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_wr_n,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic                per_ack_n,
  input  logic                bsr_stb,
  input  logic [PC_IDX_W-1:0] bsr_sel,
  input  logic                bsr_val,
  output logic [DATA_W-1:0]   port_dout,
  output logic                obf_n,
  output logic                intr
);
  localparam int CTRL_W = 2;

  logic [CTRL_W-1:0] ctrl_s;
  logic              wr_s;
  logic              ack_s;
  logic [DATA_W-1:0] wdata_d;
  edge_t             wr_ev;
  logic              inte;

  logic [DATA_W-1:0] port_q;
  logic              obf_n_q;
  logic              intr_q;

  // Asynchronous strobes, both idle high
  ppo_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTRL_W{1'b1}})) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n), .d({cpu_wr_n, per_ack_n}), .q(ctrl_s)
  );
  assign wr_s  = ctrl_s[1];
  assign ack_s = ctrl_s[0];

  // Data delay line matched to the strobe path
  ppo_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_align (
    .clk(clk), .rst_n(rst_n), .d(cpu_wdata), .q(wdata_d)
  );

  ppo_edge #(.RST_VAL(1'b1)) u_wr_edge (
    .clk(clk), .rst_n(rst_n), .lvl(wr_s), .ev(wr_ev)
  );

  ppo_inte #(.PORT(PORT)) u_inte (
    .clk(clk), .rst_n(rst_n), .bsr_stb(bsr_stb), .bsr_sel(bsr_sel),
    .bsr_val(bsr_val), .inte(inte)
  );

  // Latch follows the bus while the strobe is active
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     port_q <= '0;
    else if (!wr_s) port_q <= wdata_d;
  end

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_s) |-> $stable(port_q)); // R3

  // Buffer-full: set after strobe release, cleared by acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          obf_n_q <= 1'b1;
    else if (wr_ev.rise) obf_n_q <= 1'b0;
    else if (!ack_s)     obf_n_q <= 1'b1;
  end

  AST_OBF_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(obf_n_q) |-> $past(wr_ev.rise)); // R2
  AST_OBF_RISE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf_n_q) |-> $past(!ack_s)); // R4

  // Interrupt request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      intr_q <= 1'b0;
    else if (wr_ev.fall || !wr_s || !inte)
      intr_q <= 1'b0;
    else if (ack_s && obf_n_q && !wr_ev.rise)
      intr_q <= 1'b1;
  end

  AST_INTR_RISE_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_q) |-> $past(inte && ack_s && obf_n_q && wr_s)); // R5
  AST_INTR_LOW_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_s |=> !intr_q); // R6
  AST_INTR_NEEDS_INTE: assert property (@(posedge clk) disable iff (!rst_n)
    !inte |=> !intr_q); // R8

  assign port_dout = port_q;
  assign obf_n     = obf_n_q;
  assign intr      = intr_q;
endmodule

// File: tb/strobed_out_port_tb.sv
module strobed_out_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr_n = 1'b1;
  logic [7:0] cpu_wdata = 8'h00;
  logic       per_ack_n = 1'b1;
  logic       bsr_stb = 1'b0;
  logic [2:0] bsr_sel = 3'd0;
  logic       bsr_val = 1'b0;
  logic [7:0] port_dout;
  logic       obf_n;
  logic       intr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  strobed_out_port dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr_n(cpu_wr_n), .cpu_wdata(cpu_wdata),
    .per_ack_n(per_ack_n), .bsr_stb(bsr_stb), .bsr_sel(bsr_sel),
    .bsr_val(bsr_val), .port_dout(port_dout), .obf_n(obf_n), .intr(intr)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // {wr_n, ack_n, data, bsr_stb, bsr_sel, bsr_val, exp_port, exp_obf_n, exp_intr}
  localparam int NV = 13;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'h00, 1'b1, 3'd6, 1'b1, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b1, 8'hA5, 1'b0, 3'd0, 1'b0, 8'hA5, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'h3C, 1'b0, 3'd0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h3C, 1'b0, 3'd0, 1'b0, 8'hA5, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'h3C, 1'b0, 3'd0, 1'b0, 8'hA5, 1'b1, 1'b1},
    {1'b1, 1'b1, 8'h3C, 1'b1, 3'd5, 1'b0, 8'hA5, 1'b1, 1'b1},
    {1'b0, 1'b1, 8'h5A, 1'b0, 3'd0, 1'b0, 8'h5A, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'hFF, 1'b0, 3'd0, 1'b0, 8'h5A, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'hFF, 1'b1, 3'd6, 1'b0, 8'h5A, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'hFF, 1'b0, 3'd0, 1'b0, 8'h5A, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'hFF, 1'b0, 3'd0, 1'b0, 8'h5A, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'hFF, 1'b1, 3'd6, 1'b1, 8'h5A, 1'b1, 1'b1}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1";
      1: return "R5";
      2: return "R6";
      3: return "R2";
      4: return "R4";
      5: return "R5";
      6: return "R7";
      7: return "R2";
      8: return "R3";
      9: return "R8";
      10: return "R4";
      11: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    // Reset state (R1)
    repeat (3) @(negedge clk);
    chk("R1", "port_dout in reset", port_dout, 8'h00);
    chk("R1", "obf_n in reset", obf_n, 1'b1);
    chk("R1", "intr in reset", intr, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      cpu_wr_n  = v[24];
      per_ack_n = v[23];
      cpu_wdata = v[22:15];
      bsr_stb   = v[14];
      bsr_sel   = v[13:11];
      bsr_val   = v[10];
      @(negedge clk);
      bsr_stb = 1'b0;
      repeat (5) @(negedge clk);
      chk(vec_tag(i), $sformatf("vec%0d port_dout", i), port_dout, v[9:2]);
      chk(vec_tag(i), $sformatf("vec%0d obf_n", i), obf_n, v[1]);
      chk(vec_tag(i), $sformatf("vec%0d intr", i), intr, v[0]);
    end

    // Latency of the write falling edge (R9, R6); intr is high here
    cpu_wr_n = 1'b0; cpu_wdata = 8'h77;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9", "intr before third edge", intr, 1'b1);
    chk("R9", "port_dout before third edge", port_dout, 8'h5A);
    @(posedge clk); @(negedge clk);
    chk("R6", "intr at third edge after strobe fall", intr, 1'b0);
    chk("R2", "port_dout during strobe", port_dout, 8'h77);
    repeat (2) @(negedge clk);

    // Strobe release: obf_n falls on the third edge, latch already valid (R9, R2)
    cpu_wr_n = 1'b1; cpu_wdata = 8'h11;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9", "obf_n before third edge", obf_n, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R2", "obf_n after strobe release", obf_n, 1'b0);
    chk("R2", "port_dout when obf_n falls", port_dout, 8'h77);
    repeat (4) @(negedge clk);
    chk("R4", "obf_n held without ack", obf_n, 1'b0);
    chk("R3", "port_dout ignores bus", port_dout, 8'h77);

    // Acknowledge low, then high: obf_n and intr timing (R9, R4, R5)
    per_ack_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9", "obf_n before third edge after ack", obf_n, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R4", "obf_n released by ack", obf_n, 1'b1);
    chk("R5", "intr low while ack held", intr, 1'b0);
    per_ack_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9", "intr before third edge after ack release", intr, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R5", "intr after ack release", intr, 1'b1);

    // Reset mid-transfer with buffer full (R1)
    cpu_wr_n = 1'b0; cpu_wdata = 8'h99;
    repeat (4) @(negedge clk);
    cpu_wr_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2", "obf_n before reset", obf_n, 1'b0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "port_dout after reset", port_dout, 8'h00);
    chk("R1", "obf_n after reset", obf_n, 1'b1);
    chk("R1", "intr after reset", intr, 1'b0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1", "enable cleared by reset, no request", intr, 1'b0);

    // Other index never enables (R7)
    bsr_stb = 1'b1; bsr_sel = 3'd2; bsr_val = 1'b1;
    @(negedge clk);
    bsr_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", "index 2 ignored on A-side port", intr, 1'b0);

    // Enable, then clear: intr drops one clock after the enable is cleared (R8)
    bsr_stb = 1'b1; bsr_sel = 3'd6; bsr_val = 1'b1;
    @(negedge clk);
    bsr_stb = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5", "intr with enable and empty buffer", intr, 1'b1);
    bsr_stb = 1'b1; bsr_sel = 3'd6; bsr_val = 1'b0;
    @(negedge clk);
    bsr_stb = 1'b0;
    chk("R8", "intr before enable takes effect", intr, 1'b1);
    @(negedge clk);
    chk("R8", "intr one clock after enable cleared", intr, 1'b0);

    finish_run();
  end
endmodule